// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one output cell of a sum-of-products programmable logic device. It receives the OR of its product terms from the logic array and turns it into an output pin. It also returns one feedback signal to the array. Two configuration bits set how the cell behaves. One picks a clocked storage path or a straight-through path. The other picks whether the pin shows the true or the inverted level. A separate product term turns the pin driver on and off. When the driver is off, the pin works as an input.

The cell has one storage element, modelled as a two-state machine. `ST_LOW` moves to `ST_HIGH` on the transition *load-one*, which happens at a rising clock edge when either the preset term or the sum term is high. `ST_HIGH` moves to `ST_LOW` on *load-zero*, at a rising clock edge when both are low. The clear term acts at once on either state, with no clock edge, through the transition *force-clear* into `ST_LOW`. The device drives the same clear term at power-up, so the cell starts in `ST_LOW`. The preset and clear terms are shared by every cell in the device. The enable term belongs to this cell alone.

Top module: `pal_out_cell`

## Requirements
- R1: With `cfg_registered`=1 (registered path), each rising clock edge stores `sum_term` when neither `preset_term` nor `clear_term` is high, and `pin_out` shows the stored value after polarity.
- R2: With `cfg_registered`=0 (straight-through path), `pin_out` equals `sum_term` XOR `cfg_invert`, with no clock edge in between.
- R3: `cfg_invert`=1 inverts the pin level. On the registered path the inversion follows the storage element, so toggling `cfg_invert` changes `pin_out` at once and leaves the stored value unchanged.
- R4: `pin_oe` follows `oe_term` in both paths.
- R5: On the registered path, `array_fb` equals the stored value before inversion. It does not depend on `pin_in`, `oe_term` or `cfg_invert`.
- R6: On the straight-through path, `array_fb` equals `pin_out` when `oe_term`=1 and equals `pin_in` when `oe_term`=0.
- R7: A rising clock edge with `preset_term`=1 and `clear_term`=0 stores 1, whatever `sum_term` is.
- R8: `clear_term`=1 clears the stored value at once, with no clock edge, and keeps it cleared while it stays high. This covers the clear at power-up.
- R9: When `clear_term` and `preset_term` are both high across a clock edge, the stored value stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for the storage element |
| clear_term | input | 1 | Shared clear term, active high, asynchronous |
| preset_term | input | 1 | Shared preset term, active high, synchronous |
| sum_term | input | 1 | OR of this cell's product terms |
| oe_term | input | 1 | Product term that enables the pin driver |
| cfg_registered | input | 1 | 1 = registered path, 0 = straight-through path |
| cfg_invert | input | 1 | 1 = inverted pin level, 0 = true pin level |
| pin_in | input | 1 | Level present on the pin |
| pin_out | output | 1 | Level driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| array_fb | output | 1 | Feedback to the logic array |

## Verification
The clocked properties assume that `clear_term` changes only while the clock is low. They are turned off while `clear_term` is high, because the clear path does not wait for the clock. The bench therefore changes every input just after the falling edge, and the one mid-cycle pulse on `clear_term` is checked away from any rising edge. It holds the configuration bits steady across every rising edge it checks. It samples `pin_in` only where the cell reads it, that is, on the straight-through path with the driver off.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

    // Two-state storage element
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } cell_state_e;

    // Output path selection, encoded as the configuration bit
    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;

    localparam logic LEVEL_CLEARED = 1'b0;
    localparam logic LEVEL_PRESET  = 1'b1;

endpackage

// File: rtl/pal_mc_store.sv
module pal_mc_store
    import pal_mc_pkg::*;
(
    input  logic clk,
    input  logic clear_term,
    input  logic preset_term,
    input  logic d_in,
    output logic q_out
);

    cell_state_e state_q;
    cell_state_e state_d;

    // State register: force-clear is asynchronous
    always_ff @(posedge clk or posedge clear_term) begin
        if (clear_term) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: load-one / load-zero / hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (preset_term || d_in) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (!preset_term && !d_in) begin
                    state_d = ST_LOW;
                end
            end
            default: state_d = ST_LOW;
        endcase
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_HIGH: q_out = LEVEL_PRESET;
            default: q_out = LEVEL_CLEARED;
        endcase
    end

    AST_PRESET_LOADS_ONE: assert property (@(posedge clk) disable iff (clear_term)
        (!$past(clear_term) && $past(preset_term)) |-> q_out) // R7
        else $error("preset did not load one");

    AST_EDGE_LOADS_SUM: assert property (@(posedge clk) disable iff (clear_term)
        (!$past(clear_term) && !$past(preset_term)) |-> (q_out == $past(d_in))) // R1
        else $error("stored value does not follow sum term");

    AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk)
        clear_term |-> (state_q == ST_LOW)) // R8
        else $error("clear term did not clear the store");

    AST_CLEAR_BEATS_PRESET: assert property (@(posedge clk)
        (clear_term && preset_term) |-> !q_out) // R9
        else $error("preset overrode clear");

endmodule

// File: rtl/pal_mc_drive.sv
module pal_mc_drive
    import pal_mc_pkg::*;
(
    input  path_e path_sel,
    input  logic  invert,
    input  logic  sum_term,
    input  logic  stored,
    input  logic  oe_term,
    output logic  level_out,
    output logic  drive_en
);

    logic comb_level;
    logic reg_level;

    // Polarity is applied after the storage element
    assign comb_level = sum_term ^ invert;
    assign reg_level  = stored ^ invert;

    always_comb begin
        unique case (path_sel)
            PATH_REG:  level_out = reg_level;
            PATH_COMB: level_out = comb_level;
            default:   level_out = comb_level;
        endcase
    end

    assign drive_en = oe_term;

endmodule

// File: rtl/pal_mc_feedback.sv
module pal_mc_feedback
    import pal_mc_pkg::*;
(
    input  path_e path_sel,
    input  logic  stored,
    input  logic  drive_level,
    input  logic  drive_en,
    input  logic  pin_in,
    output logic  fb_out
);

    always_comb begin
        unique case (path_sel)
            PATH_REG:  fb_out = stored;
            PATH_COMB: fb_out = drive_en ? drive_level : pin_in;
            default:   fb_out = pin_in;
        endcase
    end

endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
    import pal_mc_pkg::*;
(
    input  logic clk,
    input  logic clear_term,
    input  logic preset_term,
    input  logic sum_term,
    input  logic oe_term,
    input  logic cfg_registered,
    input  logic cfg_invert,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic array_fb
);

    path_e path_sel;
    logic  stored;
    logic  drive_level;
    logic  drive_en;

    assign path_sel = path_e'(cfg_registered);

    pal_mc_store i_store (
        .clk         (clk),
        .clear_term  (clear_term),
        .preset_term (preset_term),
        .d_in        (sum_term),
        .q_out       (stored)
    );

    pal_mc_drive i_drive (
        .path_sel  (path_sel),
        .invert    (cfg_invert),
        .sum_term  (sum_term),
        .stored    (stored),
        .oe_term   (oe_term),
        .level_out (drive_level),
        .drive_en  (drive_en)
    );

    pal_mc_feedback i_feedback (
        .path_sel    (path_sel),
        .stored      (stored),
        .drive_level (drive_level),
        .drive_en    (drive_en),
        .pin_in      (pin_in),
        .fb_out      (array_fb)
    );

    assign pin_out = drive_level;
    assign pin_oe  = drive_en;

    AST_REG_FB_IS_TRUE_LEVEL: assert property (@(posedge clk) disable iff (clear_term)
        cfg_registered |-> (array_fb != (pin_out ^ cfg_invert ^ 1'b1))) // R5
        else $error("registered feedback not taken before inversion");

    AST_COMB_FB_READS_PIN: assert property (@(posedge clk) disable iff (clear_term)
        (!cfg_registered && !oe_term) |-> (array_fb == pin_in)) // R6
        else $error("disabled driver feedback does not read the pin");

    AST_COMB_FB_READS_OUT: assert property (@(posedge clk) disable iff (clear_term)
        (!cfg_registered && oe_term) |-> (array_fb == pin_out)) // R6
        else $error("enabled driver feedback does not read the output");

    AST_COMB_PASSES_SUM: assert property (@(posedge clk) disable iff (clear_term)
        !cfg_registered |-> (pin_out == (sum_term ^ cfg_invert))) // R2
        else $error("straight-through path does not pass the sum term");

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (clear_term)
        pin_oe == oe_term) // R4
        else $error("driver enable does not follow enable term");

endmodule

// File: tb/test_pal_out_cell.sv
`timescale 1ns/1ps
module test_pal_out_cell;

    // {inv, oe, sum, pin, exp_out, exp_fb} on the straight-through path
    localparam logic [5:0] COMB_VEC [16] = '{
        6'b0000_00, 6'b0001_01, 6'b0010_10, 6'b0011_11,
        6'b0100_00, 6'b0101_00, 6'b0110_11, 6'b0111_11,
        6'b1000_10, 6'b1001_11, 6'b1010_00, 6'b1011_01,
        6'b1100_11, 6'b1101_11, 6'b1110_00, 6'b1111_00
    };

    logic clk = 1'b0;
    logic clear_term = 1'b1;
    logic preset_term = 1'b0;
    logic sum_term = 1'b0;
    logic oe_term = 1'b0;
    logic cfg_registered = 1'b1;
    logic cfg_invert = 1'b0;
    logic pin_in = 1'b0;
    logic pin_out;
    logic pin_oe;
    logic array_fb;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic model_q = 1'b0;

    always #10 clk = ~clk;

    pal_out_cell i_pal_out_cell (
        .clk            (clk),
        .clear_term     (clear_term),
        .preset_term    (preset_term),
        .sum_term       (sum_term),
        .oe_term        (oe_term),
        .cfg_registered (cfg_registered),
        .cfg_invert     (cfg_invert),
        .pin_in         (pin_in),
        .pin_out        (pin_out),
        .pin_oe         (pin_oe),
        .array_fb       (array_fb)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R8: clear at power-up, registered path
        #5;
        check("R8 reset out", pin_out, 1'b0);
        check("R8 reset fb", array_fb, 1'b0);
        check("R4 reset oe", pin_oe, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        clear_term = 1'b0;

        // Straight-through table: R2, R4, R6
        cfg_registered = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            {cfg_invert, oe_term, sum_term, pin_in} = COMB_VEC[i][5:2];
            #2;
            check("R2 comb out", pin_out, COMB_VEC[i][1]);
            check("R6 comb fb", array_fb, COMB_VEC[i][0]);
            check("R4 comb oe", pin_oe, COMB_VEC[i][4]);
        end

        // Registered path with a bench model: R1, R3, R5, R7
        @(negedge clk);
        clear_term = 1'b1;
        cfg_registered = 1'b1;
        preset_term = 1'b0;
        @(negedge clk);
        clear_term = 1'b0;
        model_q = 1'b0;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            sum_term    = k[0] ^ k[2];
            cfg_invert  = k[1];
            oe_term     = k[3];
            pin_in      = k[4];
            preset_term = ((k % 5) == 3);
            @(posedge clk);
            model_q = preset_term ? 1'b1 : sum_term;
            #5;
            check("R1 reg out", pin_out, model_q ^ cfg_invert);
            check("R5 reg fb", array_fb, model_q);
            check("R4 reg oe", pin_oe, oe_term);
        end

        // R3: invert toggled with no clock, store unchanged
        @(negedge clk);
        preset_term = 1'b0; sum_term = 1'b1; cfg_invert = 1'b0;
        oe_term = 1'b0; pin_in = 1'b0;
        @(posedge clk);
        #3;
        cfg_invert = 1'b1;
        #1;
        check("R3 invert after store", pin_out, 1'b0);
        check("R5 fb before invert, pin ignored", array_fb, 1'b1);

        // R8: mid-cycle clear with no clock edge
        @(negedge clk);
        #3;
        clear_term = 1'b1;
        #1;
        check("R8 async clear out", pin_out, 1'b1);
        check("R8 async clear fb", array_fb, 1'b0);

        // R9: clear beats preset across an edge
        @(negedge clk);
        preset_term = 1'b1; sum_term = 1'b1;
        @(posedge clk);
        #5;
        check("R9 clear wins", array_fb, 1'b0);

        // R7: preset beats a zero sum
        @(negedge clk);
        clear_term = 1'b0; preset_term = 1'b1; sum_term = 1'b0;
        @(posedge clk);
        #5;
        check("R7 preset loads one", array_fb, 1'b1);
        check("R7 preset pin level", pin_out, 1'b0);

        // R1: load-zero once preset drops
        @(negedge clk);
        preset_term = 1'b0;
        @(posedge clk);
        #5;
        check("R1 load zero", array_fb, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule